// File: doc/BRIEF.md
# Dual-Clock FIFO Threshold Flags

This block produces the two programmable level flags of a dual-clock FIFO. A read-side flag, `near_empty_n`, is driven low when the FIFO is close to empty. A write-side flag, `near_full_n`, is driven low when the FIFO is close to full. Each flag belongs to its own clock domain. Each one works out the fill level from the pointer of its own port and a synchronized copy of the pointer of the far port.

The FIFO core around the block supplies the pointers. Each port gives a binary pointer and a Gray-coded copy of it. Both carry one wrap bit above the address bits. The read pointer must already count a word that has been moved into the output register, so that word is not part of the fill level.

The two thresholds are the low mark X and the high mark Y. Both reset to parameter presets. During a fixed number of write-clock cycles after the write reset is released, they can be rewritten from a small programming port in the write domain. After that window the programming port is ignored.

Top module: `fifo_level_flags`

## Requirements
- R1: With fill level n = (synchronized write pointer − read pointer), `near_empty_n` is 0 when n ≤ X and 1 when n ≥ X+1.
- R2: With fill level n = (write pointer − synchronized read pointer), `near_full_n` is 0 when n ≥ DEPTH−Y and 1 when n ≤ DEPTH−Y−1.
- R3: A change of a flag's own-domain pointer affects that flag at once, with no clock edge needed: a read lowers n for `near_empty_n` and a write raises n for `near_full_n`.
- R4: A change of the far-side Gray pointer is seen by a flag at the second rising edge of that flag's own clock after the change, and not at the first.
- R5: If the synchronized far pointer and the threshold copy do not change, a flag cannot rise. A read alone never raises `near_empty_n`, and a write alone never raises `near_full_n`.
- R6: After reset, X equals AE_PRESET and Y equals AF_PRESET. With both pointers at zero, `near_empty_n` is 0 and `near_full_n` is 1.
- R7: A write-clock edge with `cfg_wr` = 1, within PROG_WIN write cycles after the write reset is released, loads `cfg_data` into X when `cfg_sel` = 0 and into Y when `cfg_sel` = 1. The new X governs `near_empty_n` after at most SYNC_STAGES read-clock edges.
- R8: A `cfg_wr` asserted after the window has closed changes neither threshold.
- R9: Pointers are DEPTH-modulo with one wrap bit (width log2(DEPTH)+1). The fill level is correct across pointer wrap, and a level of exactly DEPTH counts as full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, active low |
| wr_ptr | input | log2(DEPTH)+1 | Binary write pointer with wrap bit |
| wr_ptr_gray | input | log2(DEPTH)+1 | Gray copy of the write pointer, for the read domain |
| cfg_wr | input | 1 | Threshold programming strobe (write domain) |
| cfg_sel | input | 1 | 0 selects the low mark X, 1 selects the high mark Y |
| cfg_data | input | log2(DEPTH)+1 | Threshold value to load |
| near_full_n | output | 1 | Low when the FIFO holds DEPTH−Y or more words |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, active low |
| rd_ptr | input | log2(DEPTH)+1 | Binary read pointer with wrap bit, counting the output-register word |
| rd_ptr_gray | input | log2(DEPTH)+1 | Gray copy of the read pointer, for the write domain |
| near_empty_n | output | 1 | Low when the FIFO holds X or fewer words |

## Verification
The bench checks each flag one edge before and at the edge where a far-side change should appear. A synchronizer that is one stage short shows the change early, and one that is a stage too long shows it late. It walks the level through X, X+1, DEPTH−Y−1, DEPTH−Y and DEPTH, so an off-by-one or a non-inclusive compare shows up as a flag wrong by one word. The pointers are driven around the wrap point, where a compare that drops the wrap bit reports a full FIFO as empty. A late programming write is sent and then tested at a level where the ignored value would flip the flag, which exposes a window that never closes.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;

    // threshold selector on the programming port
    typedef enum logic {
        MARK_LOW  = 1'b0,
        MARK_HIGH = 1'b1
    } mark_sel_e;

    localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/fifo_flag_sync.sv
// Multi-flop synchronizer; GRAY variant converts the last stage to binary.
module fifo_flag_sync #(
    parameter int          W       = 5,
    parameter int          STAGES  = 2,
    parameter bit          GRAY    = 1'b1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.pipe[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                st_q.pipe[s] <= RST_VAL;
            end
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (GRAY) begin : g_gray
            logic [W-1:0] bin;
            always_comb begin
                bin[W-1] = st_q.pipe[STAGES-1][W-1];
                for (int i = W - 2; i >= 0; i--) begin
                    bin[i] = bin[i+1] ^ st_q.pipe[STAGES-1][i];
                end
            end
            assign dout = bin;
        end else begin : g_plain
            assign dout = st_q.pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/fifo_flag_cfg.sv
// Threshold registers with a programming window after write reset.
module fifo_flag_cfg
    import fifo_flag_pkg::*;
#(
    parameter int OW       = 5,
    parameter int PROG_WIN = 8,
    parameter int LO_PRE   = 2,
    parameter int HI_PRE   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_sel,
    input  logic [OW-1:0] cfg_data,
    output logic [OW-1:0] low_mark,
    output logic [OW-1:0] high_mark,
    output logic          win_open
);

    localparam int CW = $clog2(PROG_WIN + 1);
    localparam logic [CW-1:0] WIN_END = CW'(PROG_WIN);

    typedef struct packed {
        logic [CW-1:0] age;
        logic [OW-1:0] lo;
        logic [OW-1:0] hi;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    open_w;

    assign open_w = (st_q.age != WIN_END);

    always_comb begin
        st_d = st_q;
        if (open_w) begin
            st_d.age = st_q.age + 1'b1;
        end
        if (cfg_wr && open_w) begin
            if (mark_sel_e'(cfg_sel) == MARK_LOW) begin
                st_d.lo = cfg_data;
            end else begin
                st_d.hi = cfg_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.age <= '0;
            st_q.lo  <= OW'(LO_PRE);
            st_q.hi  <= OW'(HI_PRE);
        end else begin
            st_q <= st_d;
        end
    end

    assign low_mark  = st_q.lo;
    assign high_mark = st_q.hi;
    assign win_open  = open_w;

endmodule

// File: rtl/fifo_flag_cmp.sv
// Fill-level compare; FULL_SIDE picks the almost-full or almost-empty rule.
module fifo_flag_cmp #(
    parameter int DEPTH     = 16,
    parameter bit FULL_SIDE = 1'b0
) (
    input  logic [$clog2(DEPTH):0] local_ptr,
    input  logic [$clog2(DEPTH):0] remote_ptr,
    input  logic [$clog2(DEPTH):0] offset,
    output logic                   flag_n
);

    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW:0] DEPTH_V = (PW + 1)'(DEPTH);

    logic [PW-1:0] fill;

    generate
        if (FULL_SIDE) begin : g_full
            logic [PW:0] limit;
            assign fill   = local_ptr - remote_ptr;
            assign limit  = DEPTH_V - {1'b0, offset};
            assign flag_n = ({1'b0, fill} < limit);
        end else begin : g_empty
            assign fill   = remote_ptr - local_ptr;
            assign flag_n = (fill > offset);
        end
    endgenerate

endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PROG_WIN    = 8,
    parameter int AE_PRESET   = 2,
    parameter int AF_PRESET   = 3
) (
    input  logic                   wr_clk,
    input  logic                   wr_rst_n,
    input  logic [$clog2(DEPTH):0] wr_ptr,
    input  logic [$clog2(DEPTH):0] wr_ptr_gray,
    input  logic                   cfg_wr,
    input  logic                   cfg_sel,
    input  logic [$clog2(DEPTH):0] cfg_data,
    output logic                   near_full_n,
    input  logic                   rd_clk,
    input  logic                   rd_rst_n,
    input  logic [$clog2(DEPTH):0] rd_ptr,
    input  logic [$clog2(DEPTH):0] rd_ptr_gray,
    output logic                   near_empty_n
);

    localparam int PW = $clog2(DEPTH) + 1;

    logic [PW-1:0] wr_sync_bin;
    logic [PW-1:0] rd_sync_bin;
    logic [PW-1:0] low_mark_w;
    logic [PW-1:0] high_mark_w;
    logic [PW-1:0] low_mark_rd;
    logic          cfg_open;

    // write pointer into the read domain
    fifo_flag_sync #(.W(PW), .STAGES(SYNC_STAGES), .GRAY(1'b1), .RST_VAL('0)) u_wsync (
        .clk  (rd_clk),
        .rst_n(rd_rst_n),
        .din  (wr_ptr_gray),
        .dout (wr_sync_bin)
    );

    // read pointer into the write domain
    fifo_flag_sync #(.W(PW), .STAGES(SYNC_STAGES), .GRAY(1'b1), .RST_VAL('0)) u_rsync (
        .clk  (wr_clk),
        .rst_n(wr_rst_n),
        .din  (rd_ptr_gray),
        .dout (rd_sync_bin)
    );

    fifo_flag_cfg #(.OW(PW), .PROG_WIN(PROG_WIN), .LO_PRE(AE_PRESET), .HI_PRE(AF_PRESET)) u_cfg (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .low_mark (low_mark_w),
        .high_mark(high_mark_w),
        .win_open (cfg_open)
    );

    // quasi-static low mark copied into the read domain
    fifo_flag_sync #(.W(PW), .STAGES(SYNC_STAGES), .GRAY(1'b0), .RST_VAL(PW'(AE_PRESET))) u_xsync (
        .clk  (rd_clk),
        .rst_n(rd_rst_n),
        .din  (low_mark_w),
        .dout (low_mark_rd)
    );

    fifo_flag_cmp #(.DEPTH(DEPTH), .FULL_SIDE(1'b0)) u_empty_cmp (
        .local_ptr (rd_ptr),
        .remote_ptr(wr_sync_bin),
        .offset    (low_mark_rd),
        .flag_n    (near_empty_n)
    );

    fifo_flag_cmp #(.DEPTH(DEPTH), .FULL_SIDE(1'b1)) u_full_cmp (
        .local_ptr (wr_ptr),
        .remote_ptr(rd_sync_bin),
        .offset    (high_mark_w),
        .flag_n    (near_full_n)
    );

endmodule

// File: rtl/fifo_level_flags_chk.sv
module fifo_level_flags_chk #(
    parameter int DEPTH = 16
) (
    input logic                   wr_clk,
    input logic                   wr_rst_n,
    input logic                   rd_clk,
    input logic                   rd_rst_n,
    input logic [$clog2(DEPTH):0] wr_sync_bin,
    input logic [$clog2(DEPTH):0] rd_sync_bin,
    input logic [$clog2(DEPTH):0] low_mark_w,
    input logic [$clog2(DEPTH):0] high_mark_w,
    input logic [$clog2(DEPTH):0] low_mark_rd,
    input logic                   cfg_open,
    input logic                   near_empty_n,
    input logic                   near_full_n
);

    // R5
    empty_rise_needs_write_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ($stable(wr_sync_bin) && $stable(low_mark_rd)) |-> !$rose(near_empty_n));

    // R5
    full_rise_needs_read_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        ($stable(rd_sync_bin) && $stable(high_mark_w)) |-> !$rose(near_full_n));

    // R8
    low_mark_frozen_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !cfg_open |=> $stable(low_mark_w));

    // R8
    high_mark_frozen_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !cfg_open |=> $stable(high_mark_w));

    // R7
    window_stays_closed_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !cfg_open |=> !cfg_open);

endmodule

bind fifo_level_flags fifo_level_flags_chk #(.DEPTH(DEPTH)) u_chk (
    .wr_clk      (wr_clk),
    .wr_rst_n    (wr_rst_n),
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .wr_sync_bin (wr_sync_bin),
    .rd_sync_bin (rd_sync_bin),
    .low_mark_w  (low_mark_w),
    .high_mark_w (high_mark_w),
    .low_mark_rd (low_mark_rd),
    .cfg_open    (cfg_open),
    .near_empty_n(near_empty_n),
    .near_full_n (near_full_n)
);

// File: tb/fifo_level_flags_tb.sv
module fifo_level_flags_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int PW         = $clog2(DEPTH) + 1;
    localparam int PMOD       = 2 * DEPTH;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n, rd_rst_n;
    logic [PW-1:0] wr_ptr, wr_ptr_gray, rd_ptr, rd_ptr_gray, cfg_data;
    logic          cfg_wr, cfg_sel;
    logic          near_full_n, near_empty_n;

    typedef struct {
        bit    full_side;
        bit    exp;
        int    edges;
        string tag;
    } item_t;

    item_t q[$];
    int    n_cmp  = 0;
    int    n_bad  = 0;
    int    wcnt   = 0;
    int    rcnt   = 0;
    int    x_m    = 2;
    int    y_m    = 3;
    string phase  = "";
    bit    done   = 0;

    always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #(CLK_PERIOD / 2) rd_clk = ~rd_clk;
    end

    fifo_level_flags #(.DEPTH(DEPTH), .SYNC_STAGES(2), .PROG_WIN(8), .AE_PRESET(2), .AF_PRESET(3)) u_dut (
        .wr_clk      (wr_clk),
        .wr_rst_n    (wr_rst_n),
        .wr_ptr      (wr_ptr),
        .wr_ptr_gray (wr_ptr_gray),
        .cfg_wr      (cfg_wr),
        .cfg_sel     (cfg_sel),
        .cfg_data    (cfg_data),
        .near_full_n (near_full_n),
        .rd_clk      (rd_clk),
        .rd_rst_n    (rd_rst_n),
        .rd_ptr      (rd_ptr),
        .rd_ptr_gray (rd_ptr_gray),
        .near_empty_n(near_empty_n)
    );

    function automatic int level();
        return (wcnt - rcnt + PMOD) % PMOD;
    endfunction

    function automatic bit exp_empty_n();
        return level() > x_m;
    endfunction

    function automatic bit exp_full_n();
        return level() < DEPTH - y_m;
    endfunction

    task automatic drive_ptrs();
        wr_ptr      = PW'(wcnt);
        wr_ptr_gray = PW'(wcnt ^ (wcnt >> 1));
        rd_ptr      = PW'(rcnt);
        rd_ptr_gray = PW'(rcnt ^ (rcnt >> 1));
    endtask

    task automatic check(input string tag, input bit act, input bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] got %0b expected %0b (level %0d)", tag, phase, act, exp, level());
        end
    endtask

    task automatic push(input bit fs, input bit e, input int n, input string tag);
        item_t it;
        it.full_side = fs;
        it.exp       = e;
        it.edges     = n;
        it.tag       = tag;
        q.push_back(it);
    endtask

    // monitor: pops expected items and compares after the stated edges
    initial begin
        forever begin
            item_t it;
            wait (q.size() > 0);
            it = q[0];
            for (int k = 0; k < it.edges; k++) begin
                if (it.full_side) @(posedge wr_clk);
                else              @(posedge rd_clk);
            end
            #1;
            check(it.tag, it.full_side ? near_full_n : near_empty_n, it.exp);
            void'(q.pop_front());
        end
    end

    task automatic drain();
        wait (q.size() == 0);
    endtask

    // one write; R3 for the local flag, R4 then R1 for the far flag
    task automatic do_write();
        bit old_e;
        @(negedge rd_clk);
        old_e = exp_empty_n();
        wcnt  = (wcnt + 1) % PMOD;
        drive_ptrs();
        push(1'b1, exp_full_n(), 0, "R2 R3 write lowers near_full_n at once");
        push(1'b0, old_e, 1, "R4 near_empty_n unchanged after first read edge");
        push(1'b0, exp_empty_n(), 1, "R1 near_empty_n after second read edge");
        drain();
    endtask

    // one read; R3 for the local flag, R4 then R2 for the far flag
    task automatic do_read();
        bit old_f;
        @(negedge wr_clk);
        old_f = exp_full_n();
        rcnt  = (rcnt + 1) % PMOD;
        drive_ptrs();
        push(1'b0, exp_empty_n(), 0, "R1 R3 read lowers near_empty_n at once");
        push(1'b1, old_f, 1, "R4 near_full_n unchanged after first write edge");
        push(1'b1, exp_full_n(), 1, "R2 near_full_n after second write edge");
        drain();
    endtask

    task automatic prog(input bit sel, input int val);
        @(negedge wr_clk);
        cfg_wr   = 1'b1;
        cfg_sel  = sel;
        cfg_data = PW'(val);
        @(negedge wr_clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic do_reset();
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        cfg_wr   = 1'b0;
        cfg_sel  = 1'b0;
        cfg_data = '0;
        wcnt     = 0;
        rcnt     = 0;
        x_m      = 2;
        y_m      = 3;
        drive_ptrs();
        repeat (3) @(negedge wr_clk);
        wr_rst_n = 1'b1;
        @(negedge rd_clk);
        rd_rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        @(negedge rd_clk);
        phase = "reset";
        check("R6 near_empty_n after reset", near_empty_n, 1'b0);
        check("R6 near_full_n after reset", near_full_n, 1'b1);

        phase = "fill";
        for (int i = 0; i < DEPTH; i++) do_write();
        phase = "full";
        check("R9 near_full_n at exactly DEPTH", near_full_n, 1'b0);
        phase = "drain";
        for (int i = 0; i < DEPTH; i++) do_read();

        phase = "R9 wrap";
        for (int r = 0; r < 10; r++) begin
            for (int i = 0; i < 4; i++) do_write();
            for (int i = 0; i < 4; i++) do_read();
        end
        for (int i = 0; i < DEPTH; i++) do_write();
        check("R9 near_empty_n full across wrap", near_empty_n, 1'b1);
        for (int i = 0; i < DEPTH; i++) do_read();

        // programming window
        do_reset();
        phase = "R7 program";
        prog(1'b0, 5);
        x_m = 5;
        prog(1'b1, 6);
        y_m = 6;
        repeat (20) @(negedge wr_clk);
        phase = "R8 late program";
        prog(1'b0, 1);
        prog(1'b1, 12);
        repeat (6) @(negedge rd_clk);
        for (int i = 0; i < 2; i++) do_write();
        check("R8 late low-mark write ignored", near_empty_n, 1'b0);
        phase = "R7 thresholds";
        for (int i = 2; i < 12; i++) do_write();
        for (int i = 0; i < 12; i++) do_read();

        repeat (4) @(negedge wr_clk);
        finish_run();
    end

endmodule